// File: doc/BRIEF.md
# Trace Sample Word Packer

This block sits between a processor trace port and a capture RAM. On every cycle that carries a trace sample it takes a 3-bit pipeline status, a packet field and a sync flag, formats them into a slot, and gathers slots into 32-bit words. The configured port width decides the slot size and how many slots share a word. A 4-bit port gives three byte-sized slots per word. An 8-bit port gives two 12-bit slots. A 16-bit port gives one 20-bit slot. Each finished word appears on the output with a one-cycle valid strobe, ready to be written into the RAM.

A sample can be flagged as a trigger cycle. The block then writes a reserved status code into the status field and moves the real pipeline status into the low three bits of the packet field. When capture is switched off, a partly filled word is sent out with zero padding. An empty flag then tells the controller that nothing is left in flight.

The port width and the port mode are taken in only while capture is off. Configurations that the packing cannot serve are flagged, and their samples are discarded.

Top module: `trace_word_packer`

## Requirements
- R1: Width code 0 (4-bit port): a word holds three samples, the first in bits 7:0, the next in 15:8, the third in 23:16. Each byte has status in [2:0], packet bits 3:0 in [6:3] and sync in [7]. Bits 31:24 are zero.
- R2: Width code 1 (8-bit port): a word holds two samples, the first in bits 11:0 and the second in 23:12. Each slot has status in [2:0], packet bits 7:0 in [10:3] and sync in [11]. Bits 31:24 are zero.
- R3: Width codes 2 and 3 (16-bit port): a word holds one sample, with status in [2:0], packet in [18:3] and sync in [19]. Bits 31:20 are zero.
- R4: A sample with `smp_trig` high is stored with status code 3'b110. The low three packet bits of its slot hold the sample's real status, and the higher packet bits are kept.
- R5: `word_valid` is high for exactly one cycle, starting on the clock edge after the edge that accepts the sample completing a word. `word_data` is valid in that cycle.
- R6: At a clock edge where `cap_en` is low and a word is partly filled, that word is output one cycle later with zeros in the unfilled slots.
- R7: `empty` is high when no partial word is held and `word_valid` is low. It is low while a partial word is pending.
- R8: Port mode codes are 0 (plain), 1 (demultiplexed) and 2 (multiplexed). Mode 2, mode 3, and mode 1 with any width other than code 1 raise `cfg_bad`. While `cfg_bad` is high, samples are discarded and no word is produced.
- R9: Width and mode are latched at every edge where `cap_en` is low. Changes made while `cap_en` is high have no effect on the words.
- R10: Samples presented while `cap_en` is low are discarded.
- R11: After reset, `word_valid` is 0, `word_data` is 0, `empty` is 1, and the configuration is the 16-bit plain mode, so `cfg_bad` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cap_en | input | 1 | Capture enable; low flushes and admits new configuration |
| width_sel | input | 2 | Port width code: 0 = 4-bit, 1 = 8-bit, 2 or 3 = 16-bit |
| mode_sel | input | 2 | Port mode code: 0 = plain, 1 = demultiplexed, 2 = multiplexed |
| smp_valid | input | 1 | A trace sample is present this cycle |
| smp_pipe | input | 3 | Pipeline status of the sample |
| smp_pkt | input | PKT_W | Packet field of the sample |
| smp_sync | input | 1 | Sync flag of the sample |
| smp_trig | input | 1 | Sample is a trigger cycle |
| word_valid | output | 1 | One-cycle strobe for a completed word |
| word_data | output | WORD_W | Packed word for the capture RAM |
| empty | output | 1 | No partial word pending and no word being output |
| cfg_bad | output | 1 | Latched width and mode combination is not supported |

## Verification
If the slot count or fill counter goes wrong inside the block, the mistake shows up at the ports on the next strobe. The strobe comes a cycle early or late, or the data lands in the wrong bit positions. Every table vector therefore compares the exact word against a hand-computed value in the cycle after the final sample is accepted.

A stale accumulator only becomes visible on the next word, as bits the new samples never set. For that reason the directed tests follow each discard or flush scenario with a fresh word and check it exactly. A configuration that slipped through during capture changes the layout of the very next word, and the width-change test is built to expose that.

// File: rtl/trace_pack_pkg.sv
// Package: shared codes and per-width geometry for the trace word packer.
// Assumes a 3-bit pipeline status and packets of 4, 8 or PKT_W bits.
package trace_pack_pkg;

    typedef enum logic [1:0] {
        PW4  = 2'd0,
        PW8  = 2'd1,
        PW16 = 2'd2
    } pw_e;

    typedef enum logic [1:0] {
        PM_PLAIN = 2'd0,
        PM_DEMUX = 2'd1,
        PM_MUX   = 2'd2,
        PM_RSVD  = 2'd3
    } pm_e;

    localparam int STAT_W = 3;

    // Number of slots that make up one word for a given width.
    function automatic logic [1:0] slots_of(input pw_e w);
        case (w)
            PW4:     return 2'd3;
            PW8:     return 2'd2;
            default: return 2'd1;
        endcase
    endfunction

    // Bit distance between neighbouring slots for a given width.
    function automatic logic [4:0] stride_of(input pw_e w);
        case (w)
            PW4:     return 5'd8;
            PW8:     return 5'd12;
            default: return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/pack_cfg_latch.sv
// Module: holds port width and mode. New values are taken only while capture
// is off. It also reports whether the held pair is usable.
// Assumes width code 3 is an alias of the 16-bit port.
module pack_cfg_latch
    import trace_pack_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_en,
    input  logic [1:0] width_sel,
    input  logic [1:0] mode_sel,
    output pw_e        width_q,
    output logic       legal
);

    pm_e mode_q;
    pw_e width_dec;

    // Map the raw width code onto the three supported widths.
    always_comb begin
        case (width_sel)
            2'd0:    width_dec = PW4;
            2'd1:    width_dec = PW8;
            default: width_dec = PW16;
        endcase
    end

    // Take a new configuration on every edge with capture off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q <= PW16;
            mode_q  <= PM_PLAIN;
        end else if (!cap_en) begin
            width_q <= width_dec;
            mode_q  <= pm_e'(mode_sel);
        end
    end

    // Plain mode suits any width; demultiplexed mode needs the 8-bit width.
    always_comb begin
        legal = (mode_q == PM_PLAIN) || ((mode_q == PM_DEMUX) && (width_q == PW8));
    end

endmodule

// File: rtl/trace_slot_fmt.sv
// Module: turns one trace sample into a slot for the selected width.
// A trigger sample gets the reserved status code, and its real status moves
// into the low packet bits. Purely combinational.
module trace_slot_fmt
    import trace_pack_pkg::*;
#(
    parameter int          PKT_W     = 16,
    parameter logic [2:0]  TRIG_CODE = 3'b110,
    localparam int         SLOT_MAX  = PKT_W + STAT_W + 1
) (
    input  pw_e                  width,
    input  logic [STAT_W-1:0]    pipe,
    input  logic [PKT_W-1:0]     pkt,
    input  logic                 sync,
    input  logic                 trig,
    output logic [SLOT_MAX-1:0]  slot
);

    logic [STAT_W-1:0] stat_f;
    logic [PKT_W-1:0]  pkt_f;

    // Swap in the trigger encoding when the sample is a trigger cycle.
    always_comb begin
        stat_f = trig ? TRIG_CODE : pipe;
        pkt_f  = trig ? {pkt[PKT_W-1:STAT_W], pipe} : pkt;
    end

    // Place sync, packet and status at the slot layout of the width.
    always_comb begin
        slot = '0;
        case (width)
            PW4:     slot[7:0]  = {sync, pkt_f[3:0], stat_f};
            PW8:     slot[11:0] = {sync, pkt_f[7:0], stat_f};
            default: slot       = {sync, pkt_f, stat_f};
        endcase
    end

endmodule

// File: rtl/trace_word_accum.sv
// Module: gathers slots into a word, lowest slot first. It strobes the word
// out when full, or on a stop request when partly filled.
// Assumes take and stop are never high together.
module trace_word_accum
    import trace_pack_pkg::*;
#(
    parameter int  WORD_W   = 32,
    parameter int  SLOT_MAX = 20,
    localparam int OFF_W    = $clog2(WORD_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  pw_e                 width,
    input  logic                take,
    input  logic                stop,
    input  logic [SLOT_MAX-1:0] slot,
    output logic [WORD_W-1:0]   word_data,
    output logic                word_valid,
    output logic                pending
);

    logic [WORD_W-1:0] acc_q;
    logic [1:0]        fill_q;
    logic [OFF_W-1:0]  offset;
    logic [WORD_W-1:0] merged;
    logic              last;

    // Position of the incoming slot and the word it would form.
    always_comb begin
        offset = OFF_W'(fill_q) * OFF_W'(stride_of(width));
        merged = acc_q | (WORD_W'(slot) << offset);
        last   = (fill_q == slots_of(width) - 2'd1);
    end

    // Accumulate, emit full words, and flush a partial word on stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            fill_q     <= '0;
            word_data  <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (take) begin
                if (last) begin
                    word_data  <= merged;
                    word_valid <= 1'b1;
                    acc_q      <= '0;
                    fill_q     <= '0;
                end else begin
                    acc_q  <= merged;
                    fill_q <= fill_q + 2'd1;
                end
            end else if (stop && (fill_q != 2'd0)) begin
                word_data  <= acc_q;
                word_valid <= 1'b1;
                acc_q      <= '0;
                fill_q     <= '0;
            end
        end
    end

    assign pending = (fill_q != 2'd0);

endmodule

// File: rtl/trace_word_packer.sv
// Module: top of the trace sample packer. Admits samples while capture is on
// and the configuration is usable, then formats and packs them into words.
// Assumes at most one sample per clock.
module trace_word_packer
    import trace_pack_pkg::*;
#(
    parameter int         WORD_W    = 32,
    parameter int         PKT_W     = 16,
    parameter logic [2:0] TRIG_CODE = 3'b110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [1:0]        width_sel,
    input  logic [1:0]        mode_sel,
    input  logic              smp_valid,
    input  logic [2:0]        smp_pipe,
    input  logic [PKT_W-1:0]  smp_pkt,
    input  logic              smp_sync,
    input  logic              smp_trig,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data,
    output logic              empty,
    output logic              cfg_bad
);

    localparam int SLOT_MAX = PKT_W + STAT_W + 1;

    pw_e                 cfg_width;
    logic                cfg_legal;
    logic [SLOT_MAX-1:0] slot;
    logic                take;
    logic                pending;

    pack_cfg_latch u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .width_sel (width_sel),
        .mode_sel  (mode_sel),
        .width_q   (cfg_width),
        .legal     (cfg_legal)
    );

    trace_slot_fmt #(.PKT_W(PKT_W), .TRIG_CODE(TRIG_CODE)) u_fmt (
        .width (cfg_width),
        .pipe  (smp_pipe),
        .pkt   (smp_pkt),
        .sync  (smp_sync),
        .trig  (smp_trig),
        .slot  (slot)
    );

    // A sample counts only with capture on and a usable configuration.
    always_comb begin
        take = smp_valid && cap_en && cfg_legal;
    end

    trace_word_accum #(.WORD_W(WORD_W), .SLOT_MAX(SLOT_MAX)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .width      (cfg_width),
        .take       (take),
        .stop       (!cap_en),
        .slot       (slot),
        .word_data  (word_data),
        .word_valid (word_valid),
        .pending    (pending)
    );

    assign empty   = !pending && !word_valid;
    assign cfg_bad = !cfg_legal;

endmodule

// File: rtl/trace_packer_chk.sv
// Module: assertion checker for trace_word_packer, attached by bind.
// Observes the port outputs and the latched width only.
module trace_packer_chk
    import trace_pack_pkg::*;
#(
    parameter int  WORD_W = 32,
    parameter int  PKT_W  = 16,
    localparam int LO     = PKT_W + STAT_W + 1,
    localparam int HI_W   = WORD_W - LO,
    localparam int TOP_LO = 24 - LO
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cap_en,
    input logic            word_valid,
    input logic [HI_W-1:0] word_hi,
    input logic            empty,
    input logic            cfg_bad,
    input pw_e             cfg_width
);

    AST_W4_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && cfg_width == PW4) |-> (word_hi[HI_W-1:TOP_LO] == '0)); // R1
    AST_W8_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && cfg_width == PW8) |-> (word_hi[HI_W-1:TOP_LO] == '0)); // R2
    AST_W16_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && cfg_width == PW16) |-> (word_hi == '0)); // R3
    AST_EMPTY_SETTLES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!cap_en) && !word_valid) |-> empty); // R7
    AST_BAD_CFG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bad && $past(cfg_bad)) |-> !word_valid); // R8
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cap_en) |-> $stable(cfg_width)); // R9

endmodule

bind trace_word_packer trace_packer_chk #(.WORD_W(WORD_W), .PKT_W(PKT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_en     (cap_en),
    .word_valid (word_valid),
    .word_hi    (word_data[WORD_W-1:PKT_W+4]),
    .empty      (empty),
    .cfg_bad    (cfg_bad),
    .cfg_width  (cfg_width)
);

// File: tb/tb_trace_word_packer.sv
module tb_trace_word_packer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_en = 1'b0;
    logic [1:0]  width_sel = 2'd0;
    logic [1:0]  mode_sel = 2'd0;
    logic        smp_valid = 1'b0;
    logic [2:0]  smp_pipe = '0;
    logic [15:0] smp_pkt = '0;
    logic        smp_sync = 1'b0;
    logic        smp_trig = 1'b0;
    logic        word_valid;
    logic [31:0] word_data;
    logic        empty;
    logic        cfg_bad;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    trace_word_packer dut (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .width_sel(width_sel),
        .mode_sel(mode_sel), .smp_valid(smp_valid), .smp_pipe(smp_pipe),
        .smp_pkt(smp_pkt), .smp_sync(smp_sync), .smp_trig(smp_trig),
        .word_valid(word_valid), .word_data(word_data), .empty(empty),
        .cfg_bad(cfg_bad)
    );

    typedef struct packed {
        logic [1:0]  w;
        logic [1:0]  n;
        logic        flush;
        logic [2:0]  p0; logic [15:0] k0; logic s0; logic t0;
        logic [2:0]  p1; logic [15:0] k1; logic s1; logic t1;
        logic [2:0]  p2; logic [15:0] k2; logic s2; logic t2;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 2'd3, 1'b0, 3'd1, 16'h00F5, 1'b0, 1'b0, 3'd2, 16'h000A, 1'b1, 1'b0, 3'd7, 16'h000F, 1'b0, 1'b0, 32'h007FD229}, // R1
        '{2'd1, 2'd2, 1'b0, 3'd3, 16'h0081, 1'b1, 1'b0, 3'd0, 16'h003C, 1'b0, 1'b0, 3'd0, 16'h0000, 1'b0, 1'b0, 32'h001E0C0B}, // R2
        '{2'd2, 2'd1, 1'b0, 3'd5, 16'hBEEF, 1'b1, 1'b0, 3'd0, 16'h0000, 1'b0, 1'b0, 3'd0, 16'h0000, 1'b0, 1'b0, 32'h000DF77D}, // R3
        '{2'd0, 2'd3, 1'b0, 3'd4, 16'h0009, 1'b0, 1'b1, 3'd0, 16'h0000, 1'b0, 1'b0, 3'd1, 16'h0001, 1'b1, 1'b0, 32'h00890066}, // R4
        '{2'd1, 2'd2, 1'b0, 3'd1, 16'h0000, 1'b0, 1'b0, 3'd2, 16'h00F0, 1'b1, 1'b1, 3'd0, 16'h0000, 1'b0, 1'b0, 32'h00F96001}, // R4
        '{2'd0, 2'd1, 1'b1, 3'd3, 16'h0002, 1'b1, 1'b0, 3'd0, 16'h0000, 1'b0, 1'b0, 3'd0, 16'h0000, 1'b0, 1'b0, 32'h00000093}, // R6
        '{2'd1, 2'd1, 1'b1, 3'd7, 16'h00FF, 1'b1, 1'b0, 3'd0, 16'h0000, 1'b0, 1'b0, 3'd0, 16'h0000, 1'b0, 1'b0, 32'h00000FFF}, // R6
        '{2'd0, 2'd2, 1'b1, 3'd1, 16'h0000, 1'b0, 1'b0, 3'd0, 16'h000F, 1'b1, 1'b0, 3'd0, 16'h0000, 1'b0, 1'b0, 32'h0000F801}, // R6
        '{2'd3, 2'd1, 1'b0, 3'd3, 16'h1230, 1'b0, 1'b1, 3'd0, 16'h0000, 1'b0, 1'b0, 3'd0, 16'h0000, 1'b0, 1'b0, 32'h0000919E}  // R3 R4
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic [2:0] p, input logic [15:0] k, input logic s, input logic t);
        smp_pipe = p; smp_pkt = k; smp_sync = s; smp_trig = t; smp_valid = 1'b1;
    endtask

    task automatic configure(input logic [1:0] w, input logic [1:0] m);
        cap_en = 1'b0; smp_valid = 1'b0; width_sel = w; mode_sel = m;
        tick(); tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) tick();
        rst_n = 1'b1;
        // R11 reset state
        check("R11 word_valid", 32'(word_valid), 32'd0);
        check("R11 word_data", word_data, 32'd0);
        check("R11 empty", 32'(empty), 32'd1);
        check("R11 cfg_bad", 32'(cfg_bad), 32'd0);

        // Table walk: R1 R2 R3 R4 layouts, R5 strobe timing, R6 flushes
        for (int i = 0; i < NV; i++) begin
            configure(VEC[i].w, 2'd0);
            cap_en = 1'b1;
            for (int k = 0; k < int'(VEC[i].n); k++) begin
                case (k)
                    0:       put(VEC[i].p0, VEC[i].k0, VEC[i].s0, VEC[i].t0);
                    1:       put(VEC[i].p1, VEC[i].k1, VEC[i].s1, VEC[i].t1);
                    default: put(VEC[i].p2, VEC[i].k2, VEC[i].s2, VEC[i].t2);
                endcase
                tick();
            end
            smp_valid = 1'b0;
            if (VEC[i].flush) begin
                check($sformatf("R5 no early strobe vec%0d", i), 32'(word_valid), 32'd0);
                cap_en = 1'b0;
                tick();
            end
            check($sformatf("R5 strobe vec%0d", i), 32'(word_valid), 32'd1);
            check($sformatf("R1-3/R4/R6 data vec%0d", i), word_data, VEC[i].exp);
            tick();
            check($sformatf("R5 single pulse vec%0d", i), 32'(word_valid), 32'd0);
        end

        // R9: width change during capture is ignored
        configure(2'd1, 2'd0);
        cap_en = 1'b1;
        put(3'd1, 16'h0001, 1'b0, 1'b0); tick();
        smp_valid = 1'b0; width_sel = 2'd0; tick(); tick();
        put(3'd2, 16'h0002, 1'b0, 1'b0); tick();
        smp_valid = 1'b0;
        check("R9 strobe", 32'(word_valid), 32'd1);
        check("R9 layout kept", word_data, 32'h00012009);

        // R10: samples while capture is off are discarded
        configure(2'd2, 2'd0);
        put(3'd7, 16'hFFFF, 1'b1, 1'b0);
        tick();
        check("R10 no word", 32'(word_valid), 32'd0);
        tick();
        check("R10 empty", 32'(empty), 32'd1);
        smp_valid = 1'b0;
        cap_en = 1'b1;
        put(3'd0, 16'h0001, 1'b0, 1'b0); tick();
        smp_valid = 1'b0;
        check("R10 fresh word", word_data, 32'h00000008);

        // R7: empty low while pending, low during flush strobe, then high
        configure(2'd0, 2'd0);
        cap_en = 1'b1;
        put(3'd1, 16'h0000, 1'b0, 1'b0); tick();
        smp_valid = 1'b0;
        check("R7 pending", 32'(empty), 32'd0);
        cap_en = 1'b0; tick();
        check("R7 during strobe", 32'(empty), 32'd0);
        tick();
        check("R7 settled", 32'(empty), 32'd1);

        // R8: multiplexed mode rejected, samples discarded
        configure(2'd1, 2'd2);
        check("R8 mux bad", 32'(cfg_bad), 32'd1);
        cap_en = 1'b1;
        put(3'd1, 16'h0000, 1'b0, 1'b0); tick();
        check("R8 no word a", 32'(word_valid), 32'd0);
        tick();
        smp_valid = 1'b0;
        check("R8 no word b", 32'(word_valid), 32'd0);
        check("R8 empty", 32'(empty), 32'd1);
        cap_en = 1'b0; tick();
        check("R8 no flush", 32'(word_valid), 32'd0);
        configure(2'd0, 2'd1);
        check("R8 demux 4-bit bad", 32'(cfg_bad), 32'd1);
        configure(2'd1, 2'd1);
        check("R8 demux 8-bit ok", 32'(cfg_bad), 32'd0);
        cap_en = 1'b1;
        put(3'd1, 16'h0000, 1'b0, 1'b0); tick();
        put(3'd1, 16'h0000, 1'b0, 1'b0); tick();
        smp_valid = 1'b0;
        check("R8 demux word", word_data, 32'h00001001);
        check("R8 demux strobe", 32'(word_valid), 32'd1);
        cap_en = 1'b0;
        tick();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule